// File: doc/BRIEF.md
# Forward-Rate Path Step Datapath

This block advances every forward rate of one Monte Carlo path by a single time step of a multi-factor log-normal rate model. The arithmetic is fixed point throughout. Rates arrive one per clock in increasing index order, starting at the first rate that is still alive in the current step. Each rate comes with its accrual period, its volatility vector, a Gaussian sample per factor, the step size and the square root of the step size. A start flag on the first rate of a step clears the running state. The updated rate leaves on a valid-qualified output stream in the same order.

For rate n the block forms g_n = tau_n·F_n / (1 + tau_n·F_n) with a pipelined restoring divider. It adds g_n·sigma_n into a d-wide running vector that has collected every earlier rate of the step. The drift is the dot product of sigma_n with that vector. The shock is the dot product of sigma_n with the Gaussian samples, scaled by sqrt(dt). The new rate is F·(1 + drift·dt + shock·sqrt(dt)), clipped to the range of the rate format. Every stage is registered, so a new rate is accepted on every clock with no stall.

Top module: `fr_path_step`

## Requirements
- R1: While reset is asserted, and after it until the first accepted rate has crossed the pipeline, out_valid is 0.
- R2: A rate sampled with in_valid high at a rising edge appears with out_valid high exactly QB+4 rising edges later (28 at the defaults). Back-to-back inputs give back-to-back outputs in input order, and no output appears without a matching input.
- R3: Rates, accrual periods, dt and sqrt(dt) are unsigned Q4.28. Volatilities and Gaussian samples are signed Q2.16, with factor k in bits [18k+17:18k] of in_vol and in_eps. The output is F + F·(mu·dt + sqrt(dt)·Σk sigma_k·eps_k), accurate to within 2e-6.
- R4: The drift of rate n is mu_n = Σk sigma_n,k·S_n,k. The vector S_n is the sum over rates i from the start of the step through n of sigma_i·tau_i·F_i/(1+tau_i·F_i).
- R5: A rate presented with in_first high starts a new step. Its running vector holds only its own term, whatever the earlier steps left behind.
- R6: Cycles with in_valid low leave the running vector unchanged, so idle gaps inside a step do not alter later drifts.
- R7: An update whose exact result is negative gives out_rate = 32'h0000_0000.
- R8: An update whose result exceeds the largest Q4.28 value gives out_rate = 32'hFFFF_FFFF.
- R9: A positive increment never lowers a rate, and a negative increment never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input fields hold a rate to advance |
| in_first | input | 1 | This rate opens a new time step and clears the running vector |
| in_rate | input | RW (32) | Current forward rate, unsigned Q4.28 |
| in_tau | input | RW (32) | Accrual period, unsigned Q4.28 |
| in_dt | input | RW (32) | Step size, unsigned Q4.28 |
| in_sqrt_dt | input | RW (32) | Square root of the step size, unsigned Q4.28 |
| in_vol | input | NF*VW (54) | Volatility vector, signed Q2.16 per factor |
| in_eps | input | NF*VW (54) | Standard normal samples, signed Q2.16 per factor |
| out_valid | output | 1 | out_rate holds an updated rate |
| out_rate | output | RW (32) | Updated forward rate, unsigned Q4.28, saturated |

## Verification
The bench aims at the way the running vector is carried across rates. A design that did not clear it on in_first would give a wrong first rate in the second step. A design that accumulated during idle cycles would skew every rate after a gap. Both show up as value miscompares against a real-valued model. Strongly negative and strongly positive shocks check the clipping at zero and at full scale, where a design without saturation would wrap to a large or small value. Long back-to-back runs and runs with gaps check that each result leaves exactly 28 edges after its input. A missing pipeline register, or an extra one, would move every output by a cycle.

// File: rtl/fr_pkg.sv
package fr_pkg;

    // Sideband control that travels with each rate through the pipeline.
    typedef struct packed {
        logic valid;
        logic first;
    } fr_ctl_t;

    // Default number formats.
    localparam int unsigned FR_NF_DEF    = 3;
    localparam int unsigned FR_RW_DEF    = 32;
    localparam int unsigned FR_RF_DEF    = 28;
    localparam int unsigned FR_VW_DEF    = 18;
    localparam int unsigned FR_VF_DEF    = 16;
    localparam int unsigned FR_QB_DEF    = 24;
    localparam int unsigned FR_GUARD_DEF = 8;

endpackage

// File: rtl/fr_ratio_div.sv
// Pipelined restoring divider: quotient = x / (1 + x), QB fractional bits.
// One quotient bit per stage, payload carried alongside.
module fr_ratio_div
    import fr_pkg::*;
#(
    parameter int unsigned XW   = 32,
    parameter int unsigned QB   = 24,
    parameter int unsigned PAYW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  fr_ctl_t         in_ctl,
    input  logic [XW-1:0]   in_x,
    input  logic [PAYW-1:0] in_pay,
    output fr_ctl_t         out_ctl,
    output logic [QB-1:0]   out_ratio,
    output logic [PAYW-1:0] out_pay
);

    localparam int unsigned RMW = XW + 2;

    typedef struct packed {
        fr_ctl_t         ctl;
        logic [RMW-1:0]  rem;
        logic [XW:0]     den;
        logic [QB-1:0]   quo;
        logic [PAYW-1:0] pay;
    } dstage_t;

    dstage_t stg_in;
    dstage_t stg_q [QB];

    always_comb begin
        stg_in.ctl = in_ctl;
        stg_in.rem = RMW'(in_x);
        stg_in.den = (XW+1)'(in_x) + ((XW+1)'(1) << QB);
        stg_in.quo = '0;
        stg_in.pay = in_pay;
    end

    for (genvar j = 0; j < QB; j++) begin : g_stage
        dstage_t        cur;
        dstage_t        stg_d;
        logic [RMW-1:0] dbl;
        logic           take;

        if (j == 0) begin : g_head
            assign cur = stg_in;
        end else begin : g_body
            assign cur = stg_q[j-1];
        end

        always_comb begin
            stg_d     = cur;
            dbl       = RMW'({cur.rem, 1'b0});
            take      = (dbl >= {1'b0, cur.den});
            stg_d.rem = take ? (dbl - {1'b0, cur.den}) : dbl;
            stg_d.quo = QB'({cur.quo, take});
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[j] <= '0;
            end else begin
                stg_q[j] <= stg_d;
            end
        end
    end

    assign out_ctl   = stg_q[QB-1].ctl;
    assign out_ratio = stg_q[QB-1].quo;
    assign out_pay   = stg_q[QB-1].pay;

    // R4: a finished division leaves a remainder below the divisor
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q[QB-1].ctl.valid |-> (stg_q[QB-1].rem < {1'b0, stg_q[QB-1].den}));

endmodule

// File: rtl/fr_drift_accum.sv
// Stage A: running vector S += g*sigma (cleared at step start).
// Stage B: drift = sigma . S.
module fr_drift_accum
    import fr_pkg::*;
#(
    parameter int unsigned NF    = 3,
    parameter int unsigned VW    = 18,
    parameter int unsigned QB    = 24,
    parameter int unsigned SW    = 51,
    parameter int unsigned DW    = 47,
    parameter int unsigned RESTW = 135
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fr_ctl_t          in_ctl,
    input  logic [QB-1:0]    in_g,
    input  logic [NF*VW-1:0] in_vol,
    input  logic [RESTW-1:0] in_rest,
    output logic             out_valid,
    output logic [DW-1:0]    out_drift,
    output logic [RESTW-1:0] out_rest
);

    localparam int unsigned TW = QB + 1 + VW;
    localparam int unsigned PW = VW + SW + $clog2(NF) + 1;

    typedef struct packed {
        logic                  a_v;
        logic [RESTW-1:0]      a_rest;
        logic [NF*VW-1:0]      a_vol;
        logic [NF-1:0][SW-1:0] sum;
        logic                  b_v;
        logic [DW-1:0]         b_drift;
        logic [RESTW-1:0]      b_rest;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        logic signed [TW-1:0] term;
        logic signed [SW-1:0] base;
        logic signed [PW-1:0] dot;

        st_d = st_q;

        // Stage A: fold this rate's term into the running vector
        st_d.a_v    = in_ctl.valid;
        st_d.a_rest = in_rest;
        st_d.a_vol  = in_vol;
        for (int k = 0; k < NF; k++) begin
            term = TW'($signed({1'b0, in_g})) * TW'($signed(in_vol[k*VW +: VW]));
            base = in_ctl.first ? '0 : $signed(st_q.sum[k]);
            if (in_ctl.valid) begin
                st_d.sum[k] = base + SW'(term);
            end
        end

        // Stage B: dot product of the rate's own sigma with its running vector
        dot = '0;
        for (int k = 0; k < NF; k++) begin
            dot = dot + PW'($signed(st_q.a_vol[k*VW +: VW])) * PW'($signed(st_q.sum[k]));
        end
        st_d.b_v     = st_q.a_v;
        st_d.b_drift = DW'(dot >>> QB);
        st_d.b_rest  = st_q.a_rest;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.b_v;
    assign out_drift = st_q.b_drift;
    assign out_rest  = st_q.b_rest;

    // R6: an idle input cycle leaves the running vector untouched
    p_sum_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ctl.valid |=> $stable(st_q.sum));

endmodule

// File: rtl/fr_rate_update.sv
// Stage C: increment = drift*dt + shock*sqrt(dt).
// Stage D: F + F*increment, saturated to the unsigned rate range.
module fr_rate_update #(
    parameter int unsigned RW  = 32,
    parameter int unsigned RF  = 28,
    parameter int unsigned DF  = 32,
    parameter int unsigned DW  = 47,
    parameter int unsigned SHW = 39
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_drift,
    input  logic [RW-1:0]  in_rate,
    input  logic [SHW-1:0] in_shock,
    input  logic [RW-1:0]  in_dt,
    input  logic [RW-1:0]  in_sqrt_dt,
    output logic           out_valid,
    output logic [RW-1:0]  out_rate
);

    localparam int unsigned M1W = DW + RW + 1;
    localparam int unsigned M2W = SHW + RW + 1;
    localparam int unsigned AW  = ((M1W > M2W) ? M1W : M2W) + 1;
    localparam int unsigned IW  = AW - RF;
    localparam int unsigned PW2 = RW + 1 + IW;

    typedef struct packed {
        logic          c_v;
        logic [RW-1:0] c_rate;
        logic [IW-1:0] c_incr;
        logic          o_v;
        logic [RW-1:0] o_rate;
    } upd_st_t;

    upd_st_t st_d, st_q;

    always_comb begin
        logic signed [M1W-1:0] drift_term;
        logic signed [M2W-1:0] shock_term;
        logic signed [AW-1:0]  incr_full;
        logic signed [PW2-1:0] delta;
        logic signed [PW2-1:0] next_rate;

        st_d = st_q;

        // Stage C
        drift_term  = M1W'($signed(in_drift)) * M1W'($signed({1'b0, in_dt}));
        shock_term  = M2W'($signed(in_shock)) * M2W'($signed({1'b0, in_sqrt_dt}));
        incr_full   = AW'(drift_term) + AW'(shock_term);
        st_d.c_v    = in_valid;
        st_d.c_rate = in_rate;
        st_d.c_incr = IW'(incr_full >>> RF);

        // Stage D
        delta     = PW2'($signed({1'b0, st_q.c_rate})) * PW2'($signed(st_q.c_incr));
        next_rate = PW2'($signed({1'b0, st_q.c_rate})) + (delta >>> DF);
        st_d.o_v  = st_q.c_v;
        if (next_rate[PW2-1]) begin
            st_d.o_rate = '0;
        end else if (|next_rate[PW2-2:RW]) begin
            st_d.o_rate = '1;
        end else begin
            st_d.o_rate = next_rate[RW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_v;
    assign out_rate  = st_q.o_rate;

    // R9: a non-negative increment never lowers the rate
    p_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.c_v && !st_q.c_incr[IW-1]) |=> (st_q.o_rate >= $past(st_q.c_rate)));

    // R9: a negative increment never raises the rate
    p_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.c_v && st_q.c_incr[IW-1]) |=> (st_q.o_rate <= $past(st_q.c_rate)));

endmodule

// File: rtl/fr_path_step.sv
// One time step of a log-normal multi-factor forward-rate path.
module fr_path_step
    import fr_pkg::*;
#(
    parameter int unsigned NF        = FR_NF_DEF,
    parameter int unsigned RW        = FR_RW_DEF,
    parameter int unsigned RF        = FR_RF_DEF,
    parameter int unsigned VW        = FR_VW_DEF,
    parameter int unsigned VF        = FR_VF_DEF,
    parameter int unsigned QB        = FR_QB_DEF,
    parameter int unsigned SUM_GUARD = FR_GUARD_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [RW-1:0]    in_rate,
    input  logic [RW-1:0]    in_tau,
    input  logic [RW-1:0]    in_dt,
    input  logic [RW-1:0]    in_sqrt_dt,
    input  logic [NF*VW-1:0] in_vol,
    input  logic [NF*VW-1:0] in_eps,
    output logic             out_valid,
    output logic [RW-1:0]    out_rate
);

    localparam int unsigned XW     = 2*(RW - RF) + QB;
    localparam int unsigned XSH    = 2*RF - QB;
    localparam int unsigned SHW    = 2*VW + $clog2(NF) + 1;
    localparam int unsigned TW     = QB + 1 + VW;
    localparam int unsigned SW     = TW + SUM_GUARD;
    localparam int unsigned PW     = VW + SW + $clog2(NF) + 1;
    localparam int unsigned DW     = PW - QB;
    localparam int unsigned DF     = 2*VF;
    localparam int unsigned VOLW   = NF*VW;
    localparam int unsigned RESTW  = 3*RW + SHW;
    localparam int unsigned PAYW   = VOLW + RESTW;

    // Stage 1: tau*F and the raw shock sigma.eps, computed side by side.
    typedef struct packed {
        fr_ctl_t         ctl;
        logic [XW-1:0]   x;
        logic [PAYW-1:0] pay;
    } s1_t;

    s1_t s1_d, s1_q;

    always_comb begin
        logic [2*RW-1:0]       tf;
        logic signed [SHW-1:0] shock;

        tf    = (2*RW)'(in_tau) * (2*RW)'(in_rate);
        shock = '0;
        for (int k = 0; k < NF; k++) begin
            shock = shock + SHW'($signed(in_vol[k*VW +: VW])) * SHW'($signed(in_eps[k*VW +: VW]));
        end
        s1_d.ctl.valid = in_valid;
        s1_d.ctl.first = in_first;
        s1_d.x         = XW'(tf >> XSH);
        s1_d.pay       = {in_vol, in_rate, shock, in_dt, in_sqrt_dt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    fr_ctl_t         dv_ctl;
    logic [QB-1:0]   dv_g;
    logic [PAYW-1:0] dv_pay;

    fr_ratio_div #(
        .XW   (XW),
        .QB   (QB),
        .PAYW (PAYW)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_ctl    (s1_q.ctl),
        .in_x      (s1_q.x),
        .in_pay    (s1_q.pay),
        .out_ctl   (dv_ctl),
        .out_ratio (dv_g),
        .out_pay   (dv_pay)
    );

    logic             ac_valid;
    logic [DW-1:0]    ac_drift;
    logic [RESTW-1:0] ac_rest;

    fr_drift_accum #(
        .NF    (NF),
        .VW    (VW),
        .QB    (QB),
        .SW    (SW),
        .DW    (DW),
        .RESTW (RESTW)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_ctl    (dv_ctl),
        .in_g      (dv_g),
        .in_vol    (dv_pay[PAYW-1 -: VOLW]),
        .in_rest   (dv_pay[RESTW-1:0]),
        .out_valid (ac_valid),
        .out_drift (ac_drift),
        .out_rest  (ac_rest)
    );

    fr_rate_update #(
        .RW  (RW),
        .RF  (RF),
        .DF  (DF),
        .DW  (DW),
        .SHW (SHW)
    ) u_upd (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (ac_valid),
        .in_drift   (ac_drift),
        .in_rate    (ac_rest[2*RW+SHW +: RW]),
        .in_shock   (ac_rest[2*RW +: SHW]),
        .in_dt      (ac_rest[RW +: RW]),
        .in_sqrt_dt (ac_rest[0 +: RW]),
        .out_valid  (out_valid),
        .out_rate   (out_rate)
    );

    // R2: a valid output always carries a defined rate
    p_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_rate));

    // R1: nothing leaves the pipe in the first cycle after reset
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

endmodule

// File: tb/fr_path_step_bench.sv
module fr_path_step_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NF         = 3;
    localparam int VW         = 18;
    localparam int PIPE       = 28;          // R2: QB+4 edges
    localparam real SCALE_R   = 268435456.0; // 2^28
    localparam real SCALE_V   = 65536.0;     // 2^16
    localparam real RMAX      = 4294967295.0 / 268435456.0;
    localparam real TOL       = 2.0e-6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_first = 1'b0;
    logic [31:0]        in_rate = '0;
    logic [31:0]        in_tau = '0;
    logic [31:0]        in_dt = '0;
    logic [31:0]        in_sqrt_dt = '0;
    logic [NF*VW-1:0]   in_vol = '0;
    logic [NF*VW-1:0]   in_eps = '0;
    logic               out_valid;
    logic [31:0]        out_rate;

    fr_path_step u_fr_path_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_first   (in_first),
        .in_rate    (in_rate),
        .in_tau     (in_tau),
        .in_dt      (in_dt),
        .in_sqrt_dt (in_sqrt_dt),
        .in_vol     (in_vol),
        .in_eps     (in_eps),
        .out_valid  (out_valid),
        .out_rate   (out_rate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        longint cyc;
        real    val;
        bit     sat_lo;
        bit     sat_hi;
        string  tag;
    } exp_t;

    exp_t   exp_q[$];
    exp_t   cur_e;
    longint cyc = 0;
    int     checks = 0;
    int     fails = 0;
    bit     done = 1'b0;
    real    s_run [NF];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Behavioural reference: one call per accepted rate
    task automatic push(input bit first, input real f, input real tau,
                        input real dt, input real sdt,
                        input real vol [NF], input real eps [NF], input string tag);
        logic [31:0] fq, tq, dq, sq;
        logic [VW-1:0] vq, eq;
        real fr, tr, dr, sr, g, mu, sh, ef;
        exp_t e;
        fq = 32'(longint'(f * SCALE_R));
        tq = 32'(longint'(tau * SCALE_R));
        dq = 32'(longint'(dt * SCALE_R));
        sq = 32'(longint'(sdt * SCALE_R));
        fr = real'(fq) / SCALE_R;
        tr = real'(tq) / SCALE_R;
        dr = real'(dq) / SCALE_R;
        sr = real'(sq) / SCALE_R;
        @(negedge clk);
        in_valid   = 1'b1;
        in_first   = first;
        in_rate    = fq;
        in_tau     = tq;
        in_dt      = dq;
        in_sqrt_dt = sq;
        if (first) begin
            for (int k = 0; k < NF; k++) s_run[k] = 0.0;
        end
        g  = tr * fr / (1.0 + tr * fr);
        mu = 0.0;
        sh = 0.0;
        for (int k = 0; k < NF; k++) begin
            real vr, er;
            vq = VW'(longint'(vol[k] * SCALE_V));
            eq = VW'(longint'(eps[k] * SCALE_V));
            in_vol[k*VW +: VW] = vq;
            in_eps[k*VW +: VW] = eq;
            vr = real'($signed(vq)) / SCALE_V;
            er = real'($signed(eq)) / SCALE_V;
            s_run[k] = s_run[k] + g * vr;
            mu = mu + vr * s_run[k];
            sh = sh + vr * er;
        end
        ef = fr + fr * (mu * dr + sh * sr);
        e.cyc    = cyc + 1 + PIPE;
        e.val    = ef;
        e.sat_lo = (ef < 0.0);
        e.sat_hi = (ef > RMAX);
        e.tag    = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_first = 1'b0;
        end
    endtask

    // Output monitor, compared every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                checks++;
                fails++;
                $display("FAIL R2 missing output: actual=none expected=%s result at cycle %0d",
                         exp_q[0].tag, exp_q[0].cyc);
                void'(exp_q.pop_front());
            end
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R2 unexpected output: actual=%h expected=no output", out_rate);
                end else begin
                    real act;
                    cur_e = exp_q.pop_front();
                    checks++;
                    if (cur_e.cyc != cyc) begin
                        fails++;
                        $display("FAIL R2 latency: actual cycle %0d expected cycle %0d", cyc, cur_e.cyc);
                    end
                    checks++;
                    act = real'(out_rate) / SCALE_R;
                    if (cur_e.sat_lo) begin
                        if (out_rate != 32'h0000_0000) begin
                            fails++;
                            $display("FAIL %s low clip: actual=%h expected=00000000", cur_e.tag, out_rate);
                        end
                    end else if (cur_e.sat_hi) begin
                        if (out_rate != 32'hFFFF_FFFF) begin
                            fails++;
                            $display("FAIL %s high clip: actual=%h expected=ffffffff", cur_e.tag, out_rate);
                        end
                    end else if ((act - cur_e.val > TOL) || (cur_e.val - act > TOL)) begin
                        fails++;
                        $display("FAIL %s rate: actual=%f expected=%f", cur_e.tag, act, cur_e.val);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=run still busy expected=run complete");
            summary();
            $finish;
        end
    end

    initial begin
        real v [NF];
        real e [NF];

        // R1: quiet output during reset
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL R1 in reset: actual out_valid=%b expected=0", out_valid);
            end
        end
        rst_n = 1'b1;
        // R1: quiet output after reset with no input
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL R1 after reset: actual out_valid=%b expected=0", out_valid);
            end
        end

        // Step A: back-to-back rates, drift grows along the step (R3, R4)
        for (int i = 0; i < 6; i++) begin
            for (int k = 0; k < NF; k++) begin
                v[k] = 0.22 - 0.07 * k + 0.015 * i;
                e[k] = (k == 1) ? -1.1 + 0.2 * i : 0.7 - 0.1 * i;
            end
            push(i == 0, 0.03 + 0.004 * i, 0.5, 0.25, 0.5, v, e, (i == 0) ? "R3" : "R4");
        end

        // Step B: opens right after A, then idle gaps between rates (R5, R6)
        for (int i = 0; i < 5; i++) begin
            for (int k = 0; k < NF; k++) begin
                v[k] = -0.15 + 0.1 * k + 0.02 * i;
                e[k] = 0.4 * (k + 1) - 0.3 * i;
            end
            push(i == 0, 0.05 + 0.01 * i, 0.75 + 0.05 * i, 0.5, 0.70710678, v, e,
                 (i == 0) ? "R5" : "R6");
            if (i > 0) idle(i);
        end

        // Zero volatility leaves the rate unchanged (R3)
        for (int k = 0; k < NF; k++) begin
            v[k] = 0.0;
            e[k] = 1.5;
        end
        push(1'b1, 0.0625, 1.0, 0.25, 0.5, v, e, "R3");
        idle(2);

        // Large negative shock clips at zero (R7)
        for (int k = 0; k < NF; k++) begin
            v[k] = 1.9;
            e[k] = -1.9;
        end
        push(1'b1, 2.0, 0.5, 0.0, 1.0, v, e, "R7");

        // Large positive shock clips at full scale (R8)
        for (int k = 0; k < NF; k++) begin
            v[k] = 1.9;
            e[k] = 1.9;
        end
        push(1'b1, 12.0, 0.5, 0.0, 1.0, v, e, "R8");
        idle(3);

        // Long back-to-back step with spread inputs (R2, R4, R9)
        for (int i = 0; i < 40; i++) begin
            real f, t;
            f = 0.01 + 0.09 * real'($urandom_range(0, 1000)) / 1000.0;
            t = 0.25 + 0.75 * real'($urandom_range(0, 1000)) / 1000.0;
            for (int k = 0; k < NF; k++) begin
                v[k] = -0.3 + 0.6 * real'($urandom_range(0, 1000)) / 1000.0;
                e[k] = -2.0 + 4.0 * real'($urandom_range(0, 1000)) / 1000.0;
            end
            push(i == 0, f, t, 0.25, 0.5, v, e, (i % 2 == 0) ? "R4" : "R9");
        end

        idle(PIPE + 8);

        // R2: every issued rate came back
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 drain: actual %0d results outstanding expected 0", exp_q.size());
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule